// File: doc/BRIEF.md
# Machine-Cycle State Sequencer with Reset Qualification

This block divides the oscillator clock of a small 8-bit controller core into a repeating machine cycle. Each machine cycle is six states long and every state holds two phases, so one machine cycle covers twelve clock periods. The rest of the core receives the timing as one-hot state and phase strobes. It also gets a pulse that marks the first tick of each machine cycle and an address-latch strobe that opens twice per cycle.

The block also watches the external reset pin. That pin is asynchronous, so it first passes through a synchroniser. The block accepts it as a reset only after the synchronised level has stayed high for two whole machine cycles. Once the pin falls, the internal reset is held until the next machine-cycle boundary and is released on it. While the internal reset is active, the block drives the initial value of every core register onto a wide bus, together with a mask that marks which bits of the interrupt registers are defined. Outside reset, both the bus and the mask read zero. A separate active-low power-on input puts the sequencer itself into a known state.

Top module: `mcycle_seq`

## Requirements
- R1: `state_oh_o` is one-hot, with bit 0 meaning S1 and bit 5 meaning S6. It advances one state every two clocks, S1 through S6, and then wraps back to S1.
- R2: `phase_oh_o` is one-hot, with bit 0 meaning P1 and bit 1 meaning P2. It alternates on every clock, and each state starts in P1.
- R3: `ale_o` is high during exactly four ticks: S1P2, S2P1, S4P2 and S5P1. It is low on all other ticks.
- R4: `mc_start_o` is high only during S1P1, which is once every twelve clocks.
- R5: `rst_pin_i` goes through a two-flop synchroniser. `rst_o` rises on the edge at which the synchronised level has been sampled high on 24 consecutive edges (two machine cycles). A shorter high run leaves `rst_o` low, and the count starts again from zero.
- R6: After the synchronised pin is seen low, `rst_o` falls at the edge that enters S1P1, so `rst_o` is low during that S1P1 tick. If the pin is high again at the last tick of the cycle, `rst_o` stays high.
- R7: While `rst_o` is high, `rv_o` carries the register initial values. The layout is [159:144] program counter = 0, [143:128] data pointer = 0, then bytes from bit 127 downward: accumulator, B, status word, stack pointer, timer mode, timer control, timer 0 low, timer 0 high, timer 1 low, timer 1 high, port 0, port 1, port 2, port 3, interrupt priority, interrupt enable. All of these bytes are 00 except the stack pointer, which is 07, and the four ports, which are FF. At the same time `rv_def_o` is 16'h1F9F: bits [15:8] mark the defined priority bits and bits [7:0] mark the defined enable bits. Undefined bits are driven as 0.
- R8: While `rst_o` is low, `rv_o` and `rv_def_o` are all zero.
- R9: While `arst_ni` is low, the sequencer sits at S1P1, the synchroniser and qualification count are cleared, and `rst_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock; one period is one phase |
| arst_ni | input | 1 | Active-low asynchronous power-on reset of the sequencer |
| rst_pin_i | input | 1 | Asynchronous external reset pin, active high |
| state_oh_o | output | 6 | One-hot state strobe, bit 0 = S1 |
| phase_oh_o | output | 2 | One-hot phase strobe, bit 0 = P1 |
| mc_start_o | output | 1 | High during S1P1 |
| ale_o | output | 1 | Address-latch-enable strobe |
| rst_o | output | 1 | Qualified internal reset |
| rv_o | output | 160 | Register initial-value bus |
| rv_def_o | output | 16 | Defined-bit mask for the priority and enable bytes |

## Verification
The bench builds the block with its default parameters: six states, two phases, a two-machine-cycle qualification window and a two-stage synchroniser. With these values the 24-sample acceptance threshold can be reached in a few dozen clocks. That lets the run drive high pulses of 23 and 24 synchronised samples directly, and also interrupted runs that must restart the count. The pin is dropped at each of the twelve ticks in turn, so release is observed from every position in the machine cycle, including a drop timed to land on the last tick.

// File: rtl/mcs_pkg.sv
`timescale 1ns/1ps
package mcs_pkg;

    parameter int unsigned DW = 8;
    parameter int unsigned AW = 16;

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [AW-1:0] dptr;
        logic [DW-1:0] acc;
        logic [DW-1:0] b;
        logic [DW-1:0] psw;
        logic [DW-1:0] sp;
        logic [DW-1:0] tmod;
        logic [DW-1:0] tcon;
        logic [DW-1:0] tl0;
        logic [DW-1:0] th0;
        logic [DW-1:0] tl1;
        logic [DW-1:0] th1;
        logic [DW-1:0] p0;
        logic [DW-1:0] p1;
        logic [DW-1:0] p2;
        logic [DW-1:0] p3;
        logic [DW-1:0] ip;
        logic [DW-1:0] ie;
    } regvec_t;

    localparam int unsigned RV_W  = $bits(regvec_t);
    localparam int unsigned DEF_W = 2 * DW;

    localparam logic [DW-1:0] SP_INIT   = DW'(8'h07);
    localparam logic [DW-1:0] PORT_INIT = {DW{1'b1}};
    localparam logic [DW-1:0] IP_DEF    = DW'(8'h1F);
    localparam logic [DW-1:0] IE_DEF    = DW'(8'h9F);

    function automatic regvec_t init_vec();
        regvec_t v;
        v    = '0;
        v.sp = SP_INIT;
        v.p0 = PORT_INIT;
        v.p1 = PORT_INIT;
        v.p2 = PORT_INIT;
        v.p3 = PORT_INIT;
        return v;
    endfunction

endpackage

// File: rtl/mcs_tick_gen.sv
`timescale 1ns/1ps
module mcs_tick_gen #(
    parameter int unsigned STATES = 6,
    parameter int unsigned PHASES = 2
) (
    input  logic              clk_i,
    input  logic              arst_ni,
    output logic [STATES-1:0] state_oh_o,
    output logic [PHASES-1:0] phase_oh_o,
    output logic              mc_start_o,
    output logic              mc_last_o,
    output logic              ale_o
);

    localparam int unsigned SW    = (STATES > 1) ? $clog2(STATES) : 1;
    localparam int unsigned PW    = (PHASES > 1) ? $clog2(PHASES) : 1;
    localparam int unsigned ALE_A = 0;
    localparam int unsigned ALE_B = STATES / 2;

    typedef struct packed {
        logic [SW-1:0] st;
        logic [PW-1:0] ph;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (seq_q.ph == PW'(PHASES - 1)) begin
            seq_d.ph = '0;
            seq_d.st = (seq_q.st == SW'(STATES - 1)) ? '0 : seq_q.st + SW'(1);
        end else begin
            seq_d.ph = seq_q.ph + PW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) seq_q <= '0;
        else          seq_q <= seq_d;
    end

    for (genvar gs = 0; gs < STATES; gs++) begin : g_state
        assign state_oh_o[gs] = (seq_q.st == SW'(gs));
    end
    for (genvar gp = 0; gp < PHASES; gp++) begin : g_phase
        assign phase_oh_o[gp] = (seq_q.ph == PW'(gp));
    end

    assign mc_start_o = (seq_q.st == '0) && (seq_q.ph == '0);
    assign mc_last_o  = (seq_q.st == SW'(STATES - 1)) && (seq_q.ph == PW'(PHASES - 1));

    // Strobe opens in the last phase of state A or B and closes after the first phase of the next state
    assign ale_o = ((seq_q.ph == PW'(PHASES - 1)) &&
                    ((seq_q.st == SW'(ALE_A)) || (seq_q.st == SW'(ALE_B)))) ||
                   ((seq_q.ph == '0) &&
                    ((seq_q.st == SW'(ALE_A + 1)) || (seq_q.st == SW'(ALE_B + 1))));

    a_r1_state_onehot: assert property (@(posedge clk_i) disable iff (!arst_ni)
        $countones(state_oh_o) == 1);

    a_r1_wrap_to_s1: assert property (@(posedge clk_i) disable iff (!arst_ni)
        mc_last_o |=> mc_start_o);

    a_r2_phase_toggle: assert property (@(posedge clk_i) disable iff (!arst_ni)
        1'b1 |=> phase_oh_o != $past(phase_oh_o));

    a_r3_ale_two_ticks: assert property (@(posedge clk_i) disable iff (!arst_ni)
        $rose(ale_o) |=> ale_o);

    a_r3_ale_closes: assert property (@(posedge clk_i) disable iff (!arst_ni)
        (ale_o && $past(ale_o)) |=> !ale_o);

endmodule

// File: rtl/mcs_rst_qual.sv
`timescale 1ns/1ps
module mcs_rst_qual #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned QUAL_TICKS  = 24
) (
    input  logic clk_i,
    input  logic arst_ni,
    input  logic pin_i,
    input  logic mc_last_i,
    output logic rst_o
);

    localparam int unsigned CW = $clog2(QUAL_TICKS + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(QUAL_TICKS - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
        logic                   rst;
    } qual_t;

    qual_t q_d, q_q;
    logic  pin_s;

    assign pin_s = q_q.sync[SYNC_STAGES-1];

    always_comb begin
        q_d      = q_q;
        q_d.sync = {q_q.sync[SYNC_STAGES-2:0], pin_i};
        if (!pin_s)                q_d.cnt = '0;
        else if (q_q.cnt != CNT_TOP) q_d.cnt = q_q.cnt + CW'(1);
        if (q_q.rst) q_d.rst = !(!pin_s && mc_last_i);
        else         q_d.rst = pin_s && (q_q.cnt == CNT_TOP);
    end

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) q_q <= '0;
        else          q_q <= q_d;
    end

    assign rst_o = q_q.rst;

    a_r5_rise_needs_full_run: assert property (@(posedge clk_i) disable iff (!arst_ni)
        $rose(rst_o) |-> ($past(pin_s) && $past(q_q.cnt) == CNT_TOP));

    a_r5_low_clears_count: assert property (@(posedge clk_i) disable iff (!arst_ni)
        !pin_s |=> q_q.cnt == '0);

    a_r6_hold_while_high: assert property (@(posedge clk_i) disable iff (!arst_ni)
        (rst_o && pin_s) |=> rst_o);

endmodule

// File: rtl/mcs_rstval.sv
`timescale 1ns/1ps
module mcs_rstval
    import mcs_pkg::*;
(
    input  logic             rst_i,
    output logic [RV_W-1:0]  rv_o,
    output logic [DEF_W-1:0] def_o
);

    regvec_t init_v;

    always_comb begin
        init_v = init_vec();
        rv_o   = rst_i ? init_v : '0;
        def_o  = rst_i ? {IP_DEF, IE_DEF} : '0;
    end

endmodule

// File: rtl/mcycle_seq.sv
`timescale 1ns/1ps
module mcycle_seq
    import mcs_pkg::*;
#(
    parameter int unsigned STATES      = 6,
    parameter int unsigned PHASES      = 2,
    parameter int unsigned QUAL_MCYC   = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              arst_ni,
    input  logic              rst_pin_i,
    output logic [STATES-1:0] state_oh_o,
    output logic [PHASES-1:0] phase_oh_o,
    output logic              mc_start_o,
    output logic              ale_o,
    output logic              rst_o,
    output logic [RV_W-1:0]   rv_o,
    output logic [DEF_W-1:0]  rv_def_o
);

    localparam int unsigned TICKS      = STATES * PHASES;
    localparam int unsigned QUAL_TICKS = QUAL_MCYC * TICKS;

    logic mc_last;

    mcs_tick_gen #(
        .STATES (STATES),
        .PHASES (PHASES)
    ) i_tick (
        .clk_i      (clk_i),
        .arst_ni    (arst_ni),
        .state_oh_o (state_oh_o),
        .phase_oh_o (phase_oh_o),
        .mc_start_o (mc_start_o),
        .mc_last_o  (mc_last),
        .ale_o      (ale_o)
    );

    mcs_rst_qual #(
        .SYNC_STAGES (SYNC_STAGES),
        .QUAL_TICKS  (QUAL_TICKS)
    ) i_qual (
        .clk_i     (clk_i),
        .arst_ni   (arst_ni),
        .pin_i     (rst_pin_i),
        .mc_last_i (mc_last),
        .rst_o     (rst_o)
    );

    mcs_rstval i_rv (
        .rst_i (rst_o),
        .rv_o  (rv_o),
        .def_o (rv_def_o)
    );

    a_r6_release_on_s1p1: assert property (@(posedge clk_i) disable iff (!arst_ni)
        $fell(rst_o) |-> mc_start_o);

    a_r4_single_start: assert property (@(posedge clk_i) disable iff (!arst_ni)
        mc_start_o |=> !mc_start_o);

    a_r7_values_in_reset: assert property (@(posedge clk_i) disable iff (!arst_ni)
        rst_o |-> (rv_def_o != '0 && rv_o[DEF_W-1:0] == '0));

    a_r8_idle_bus_zero: assert property (@(posedge clk_i) disable iff (!arst_ni)
        !rst_o |-> (rv_o == '0 && rv_def_o == '0));

endmodule

// File: tb/test_mcycle_seq.sv
`timescale 1ns/1ps
module test_mcycle_seq;

    logic         clk = 1'b0;
    logic         arst_ni;
    logic         rst_pin;
    logic [5:0]   state_oh;
    logic [1:0]   phase_oh;
    logic         mc_start, ale, rst;
    logic [159:0] rv;
    logic [15:0]  rv_def;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // model state
    int m_tick = 0;
    bit m_s0 = 0, m_s1 = 0, m_rst = 0;
    int m_cnt = 0;

    localparam logic [159:0] INIT_RV = {32'h0, 24'h0, 8'h07, 48'h0, 32'hFFFF_FFFF, 16'h0};

    always #2.5 clk = ~clk;

    mcycle_seq i_mcycle_seq (
        .clk_i      (clk),
        .arst_ni    (arst_ni),
        .rst_pin_i  (rst_pin),
        .state_oh_o (state_oh),
        .phase_oh_o (phase_oh),
        .mc_start_o (mc_start),
        .ale_o      (ale),
        .rst_o      (rst),
        .rv_o       (rv),
        .rv_def_o   (rv_def)
    );

    task automatic chk(input string tag, input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        bit e_ale;
        e_ale = (m_tick == 1) || (m_tick == 2) || (m_tick == 7) || (m_tick == 8);
        chk("R1 state", 160'(state_oh), 160'(6'b1 << (m_tick / 2)));
        chk("R2 phase", 160'(phase_oh), 160'(2'b1 << (m_tick % 2)));
        chk("R3 ale", 160'(ale), 160'(e_ale));
        chk("R4 mc_start", 160'(mc_start), 160'(m_tick == 0));
        chk("R5/R6 rst", 160'(rst), 160'(m_rst));
        if (m_rst) begin
            chk("R7 rv", rv, INIT_RV);
            chk("R7 rv_def", 160'(rv_def), 160'(16'h1F9F));
        end else begin
            chk("R8 rv", rv, 160'h0);
            chk("R8 rv_def", 160'(rv_def), 160'h0);
        end
    endtask

    // drive pin for one clock, advance model, compare after the edge
    task automatic step(input bit v);
        int n_cnt;
        bit n_rst;
        rst_pin = v;
        n_cnt = m_s1 ? ((m_cnt == 23) ? 23 : m_cnt + 1) : 0;
        if (m_rst) n_rst = !(!m_s1 && m_tick == 11);
        else       n_rst = m_s1 && (m_cnt == 23);
        m_rst  = n_rst;
        m_cnt  = n_cnt;
        m_s1   = m_s0;
        m_s0   = v;
        m_tick = (m_tick + 1) % 12;
        @(negedge clk);
        compare_all();
    endtask

    task automatic hold(input bit v, input int n);
        for (int i = 0; i < n; i++) step(v);
    endtask

    initial begin
        arst_ni = 1'b0;
        rst_pin = 1'b0;
        repeat (3) @(negedge clk);
        // R9: power-on reset state
        chk("R9 state", 160'(state_oh), 160'(6'b1));
        chk("R9 phase", 160'(phase_oh), 160'(2'b1));
        chk("R9 rst", 160'(rst), 160'h0);
        arst_ni = 1'b1;
        compare_all();

        hold(0, 5);
        // R5: short pulse ignored
        hold(1, 10); hold(0, 4);
        // R5: 23 synchronised samples still short
        hold(1, 23); hold(0, 5);
        // R5: interrupted run restarts count
        hold(1, 20); hold(0, 1); hold(1, 20); hold(0, 6);
        // R5: exactly 24 samples accepted
        hold(1, 24); hold(1, 10);
        // R6: release at next S1P1
        hold(0, 30);
        // R6: drop at every tick position, plus re-rise during reset
        for (int k = 0; k < 12; k++) begin
            hold(1, 26 + k);
            hold(0, 1 + (k % 3));
            hold(1, 3);
            hold(0, 15 + k);
        end
        hold(0, 20);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule